// File: doc/BRIEF.md
# Prioritised Interrupt Combiner with Critical Vector

This block collects a bank of interrupt request lines, qualifies each one according to software settings, and presents two registered interrupt outputs to a processor core. One output is for urgent (critical) work and the other is for ordinary (non-critical) work. Each source has its own settings: level or edge detection, active sense (high/rising or low/falling), enable, and the output it is routed to. Raw requests are resynchronised to the block clock before detection.

For fast entry into critical handlers, a read-only vector word is formed. It is the programmable base word plus the index of the winning critical source, shifted left by a fixed stride. The winner is the highest-priority source that is enabled, pending and routed to the critical output. A single control bit chooses the search direction: the lowest index wins, or the highest index wins. All settings and state are reached through a single-cycle synchronous register port with registered read data.

Top module: `pic_vec_ctrl`

## Requirements
- R1: After reset: enable, route, edge mode and pending status are all zero. Sense reads 0xFFFFFFFF (all active-high). Priority control and vector base are zero. Both interrupt outputs are low.
- R2: The register map is as follows; each word is addressed on `reg_addr`.
  - 0x0: pending status.
  - 0x1: enable.
  - 0x2: masked status (read-only).
  - 0x3: route, where 1 means critical.
  - 0x4: sense, where 1 means high or rising.
  - 0x5: mode, where 1 means edge.
  - 0x6: priority control, bit 0.
  - 0x7: vector base.
  - 0x8: vector (read-only).

  Read data appears on `reg_rdata` after the rising edge on which `reg_rd` is high. Writable words read back what was written. Unmapped addresses read zero.
- R3: A level-mode status bit equals the qualified, synchronised input. Writing a one to it at 0x0 has no effect.
- R4: With sense bit 0, a level source is pending while its input is low. With sense bit 1, it is pending while its input is high.
- R5: An edge-mode status bit sets only on the selected edge (rising for sense 1, falling for sense 0). It stays set until a one is written to that bit at 0x0. The opposite edge does not set it.
- R6: Masked status equals status AND enable. A disabled source affects neither output nor the vector.
- R7: `irq_crit` is the OR of masked sources with route 1, and `irq_noncrit` is the OR of masked sources with route 0. Changing the route of a source moves it between the outputs.
- R8: The vector equals base + (winning index << 9). It equals the bare base when no routed-critical masked source is pending.
- R9: With priority bit 0 the lowest pending critical index wins. With priority bit 1 the highest wins. Indices 0 and 31 are both valid winners.
- R10: A change on a request input reaches the registered outputs on the fourth rising edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Raw interrupt requests, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_crit | output | 1 | Critical interrupt to the core |
| irq_noncrit | output | 1 | Non-critical interrupt to the core |

## Verification
A request edge takes two synchroniser edges and one status edge to show up in status. The output flop adds a fourth edge, so the bench checks an output low three edges after a stimulus and high one edge later. Register reads return one edge after the strobe. The scoreboard queues the expected word when the strobe is driven and compares it on the falling edge that follows. Every other check waits five edges after the last input or register change, so that only settled values are compared.

// File: rtl/pic_vec_pkg.sv
package pic_vec_pkg;
   typedef enum logic [3:0] {
      A_PEND   = 4'h0,
      A_ENABLE = 4'h1,
      A_MASKED = 4'h2,
      A_ROUTE  = 4'h3,
      A_SENSE  = 4'h4,
      A_MODE   = 4'h5,
      A_PRIO   = 4'h6,
      A_VBASE  = 4'h7,
      A_VECTOR = 4'h8
   } pic_addr_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pic_status.sv
module pic_status #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] sense,
   input  logic [N-1:0] edge_mode,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status
);
   logic [N-1:0] prev_q;
   logic [N-1:0] hit, lvl, nxt;

   always_comb begin
      hit = (sense & req & ~prev_q) | (~sense & ~req & prev_q);
      lvl = ~(req ^ sense);
      nxt = (edge_mode & ((status & ~clr) | hit)) | (~edge_mode & lvl);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= req;
         status <= nxt;
      end
   end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int N    = 32,
   parameter int IDXW = 5
) (
   input  logic [N-1:0]    req,
   input  logic            msb_first,
   output logic [IDXW-1:0] idx,
   output logic            any
);
   always_comb begin
      idx = '0;
      any = |req;
      if (msb_first) begin
         for (int i = 0; i < N; i++) if (req[i]) idx = IDXW'(i);
      end else begin
         for (int i = N - 1; i >= 0; i--) if (req[i]) idx = IDXW'(i);
      end
   end
endmodule

// File: rtl/pic_vec_ctrl.sv
module pic_vec_ctrl #(
   parameter int N           = 32,
   parameter int DW          = 32,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_SHIFT   = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  irq_in,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          irq_crit,
   output logic          irq_noncrit
);
   import pic_vec_pkg::*;

   localparam int IDXW = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 1 || N > DW) begin : g_bad_n
         $error("pic_vec_ctrl: N must lie in 1..DW");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pic_vec_ctrl: at least two synchroniser stages required");
      end
      if (VEC_SHIFT + IDXW > DW) begin : g_bad_shift
         $error("pic_vec_ctrl: vector offset exceeds data width");
      end
      if (AW < 4) begin : g_bad_aw
         $error("pic_vec_ctrl: address too narrow for the map");
      end
   endgenerate

   logic [N-1:0]    req_s, status, masked, crit_pend;
   logic [N-1:0]    en_q, route_q, sense_q, mode_q, clr;
   logic            prio_msb_q;
   logic [DW-1:0]   base_q, vec;
   logic [IDXW-1:0] win_idx;
   logic            win_any;
   logic [DW-1:0]   rd_mux;

   pic_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(req_s));

   assign clr = (reg_wr && reg_addr == A_PEND) ? reg_wdata[N-1:0] : '0;

   pic_status #(.N(N)) u_status (
      .clk(clk), .rst_n(rst_n), .req(req_s), .sense(sense_q),
      .edge_mode(mode_q), .clr(clr), .status(status));

   assign masked    = status & en_q;
   assign crit_pend = masked & route_q;

   pic_prio #(.N(N), .IDXW(IDXW)) u_prio (
      .req(crit_pend), .msb_first(prio_msb_q), .idx(win_idx), .any(win_any));

   assign vec = win_any ? base_q + (DW'(win_idx) << VEC_SHIFT) : base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         route_q    <= '0;
         sense_q    <= '1;
         mode_q     <= '0;
         prio_msb_q <= 1'b0;
         base_q     <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_ENABLE: en_q       <= reg_wdata[N-1:0];
            A_ROUTE:  route_q    <= reg_wdata[N-1:0];
            A_SENSE:  sense_q    <= reg_wdata[N-1:0];
            A_MODE:   mode_q     <= reg_wdata[N-1:0];
            A_PRIO:   prio_msb_q <= reg_wdata[0];
            A_VBASE:  base_q     <= reg_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         A_PEND:   rd_mux = DW'(status);
         A_ENABLE: rd_mux = DW'(en_q);
         A_MASKED: rd_mux = DW'(masked);
         A_ROUTE:  rd_mux = DW'(route_q);
         A_SENSE:  rd_mux = DW'(sense_q);
         A_MODE:   rd_mux = DW'(mode_q);
         A_PRIO:   rd_mux = DW'(prio_msb_q);
         A_VBASE:  rd_mux = base_q;
         A_VECTOR: rd_mux = vec;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata   <= '0;
         irq_crit    <= 1'b0;
         irq_noncrit <= 1'b0;
      end else begin
         if (reg_rd) reg_rdata <= rd_mux;
         irq_crit    <= |crit_pend;
         irq_noncrit <= |(masked & ~route_q);
      end
   end
endmodule

// File: rtl/pic_vec_chk.sv
module pic_vec_chk #(
   parameter int N         = 32,
   parameter int DW        = 32,
   parameter int AW        = 4,
   parameter int VEC_SHIFT = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [AW-1:0] reg_addr,
   input logic [N-1:0]  status,
   input logic [N-1:0]  masked,
   input logic [N-1:0]  route_q,
   input logic [N-1:0]  mode_q,
   input logic          prio_msb_q,
   input logic [DW-1:0] base_q,
   input logic [DW-1:0] vec,
   input logic          irq_crit,
   input logic          irq_noncrit
);
   logic [DW-1:0] pend, off, idx, lower, upper;
   logic          hit_ok, prio_ok, touch;

   always_comb begin
      pend    = DW'(masked & route_q);
      off     = vec - base_q;
      idx     = off >> VEC_SHIFT;
      hit_ok  = (idx < DW'(N)) && pend[idx[$clog2(DW)-1:0]];
      lower   = pend & ((DW'(1) << idx[$clog2(DW)-1:0]) - DW'(1));
      upper   = (pend >> idx[$clog2(DW)-1:0]) >> 1;
      prio_ok = prio_msb_q ? (upper == '0) : (lower == '0);
      touch   = reg_wr && (reg_addr == AW'(0) || reg_addr == AW'(5));
   end

   p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> (vec == base_q));

   p_vec_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |-> hit_ok);

   p_vec_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |-> prio_ok);

   p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !touch |=> ((status & $past(status & mode_q)) == $past(status & mode_q)));

   p_crit_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_crit |-> $past(|(masked & route_q)));

   p_noncrit_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_noncrit |-> $past(|(masked & ~route_q)));
endmodule

bind pic_vec_ctrl pic_vec_chk #(.N(N), .DW(DW), .AW(AW), .VEC_SHIFT(VEC_SHIFT)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .status(status), .masked(masked), .route_q(route_q), .mode_q(mode_q),
   .prio_msb_q(prio_msb_q), .base_q(base_q), .vec(vec),
   .irq_crit(irq_crit), .irq_noncrit(irq_noncrit));

// File: tb/pic_vec_ctrl_tb.sv
module pic_vec_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_crit, irq_noncrit;

   int checks = 0, errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   localparam logic [31:0] BASE = 32'h1000_0000;

   always #2ns clk = ~clk;

   pic_vec_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_crit(irq_crit), .irq_noncrit(irq_noncrit));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares read data the falling edge after the strobe
   always @(posedge clk) rd_seen <= reg_rd;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic outs(input logic c, input logic n, input string tag);
      chk({31'd0, irq_crit}, {31'd0, c}, {tag, " crit"});
      chk({31'd0, irq_noncrit}, {31'd0, n}, {tag, " noncrit"});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      outs(1'b0, 1'b0, "R1");
      rd(4'h0, 32'h0, "R1 pend");
      rd(4'h1, 32'h0, "R1 enable");
      rd(4'h3, 32'h0, "R1 route");
      rd(4'h4, 32'hFFFF_FFFF, "R1 sense");
      rd(4'h5, 32'h0, "R1 mode");
      rd(4'h8, 32'h0, "R1 vector");
      // R2 readback and unmapped
      wr(4'h7, BASE);
      rd(4'h7, BASE, "R2 base readback");
      rd(4'hF, 32'h0, "R2 unmapped");
      // R10 latency, R3 level, R7 non-critical
      wr(4'h1, 32'h8);
      irq_in[3] = 1'b1;
      repeat (3) @(negedge clk);
      chk({31'd0, irq_noncrit}, 32'd0, "R10 early");
      @(negedge clk);
      chk({31'd0, irq_noncrit}, 32'd1, "R10 on time");
      settle();
      rd(4'h0, 32'h8, "R3 level pend");
      rd(4'h2, 32'h8, "R6 masked");
      outs(1'b0, 1'b1, "R7 noncrit route");
      rd(4'h8, BASE, "R8 idle vector");
      wr(4'h0, 32'h8);
      settle();
      rd(4'h0, 32'h8, "R3 not clearable");
      irq_in[3] = 1'b0;
      settle();
      rd(4'h0, 32'h0, "R3 follows low");
      outs(1'b0, 1'b0, "R3");
      // R4 active-low level
      wr(4'h4, ~32'h20);
      settle();
      rd(4'h0, 32'h20, "R4 low active");
      irq_in[5] = 1'b1;
      settle();
      rd(4'h0, 32'h0, "R4 high inactive");
      wr(4'h4, 32'hFFFF_FFFF);
      irq_in[5] = 1'b0;
      settle();
      // R5 rising edge, critical
      wr(4'h5, 32'h80); wr(4'h3, 32'h80); wr(4'h1, 32'h80);
      irq_in[7] = 1'b1; repeat (2) @(negedge clk); irq_in[7] = 1'b0;
      settle();
      rd(4'h0, 32'h80, "R5 edge latched");
      outs(1'b1, 1'b0, "R7 crit route");
      rd(4'h8, BASE + 32'hE00, "R8 vector idx7");
      wr(4'h0, 32'h80);
      settle();
      rd(4'h0, 32'h0, "R5 w1c");
      outs(1'b0, 1'b0, "R5 cleared");
      irq_in[7] = 1'b1;
      settle();
      wr(4'h0, 32'h80);
      settle();
      rd(4'h0, 32'h0, "R5 no retrigger while high");
      irq_in[7] = 1'b0;
      settle();
      rd(4'h0, 32'h0, "R5 opposite edge ignored");
      // R5 falling edge, R9 priority direction
      irq_in[9] = 1'b1;
      settle();
      wr(4'h5, 32'h280); wr(4'h4, ~32'h200);
      wr(4'h0, 32'h200);
      settle();
      rd(4'h0, 32'h0, "R5 falling armed");
      irq_in[9] = 1'b0;
      settle();
      rd(4'h0, 32'h200, "R5 falling latched");
      wr(4'h1, 32'h280); wr(4'h3, 32'h280);
      irq_in[7] = 1'b1; repeat (2) @(negedge clk); irq_in[7] = 1'b0;
      settle();
      rd(4'h0, 32'h280, "R5 both latched");
      rd(4'h8, BASE + 32'hE00, "R9 lsb wins");
      wr(4'h6, 32'h1);
      rd(4'h6, 32'h1, "R2 prio readback");
      rd(4'h8, BASE + 32'h1200, "R9 msb wins");
      wr(4'h0, 32'h280); wr(4'h6, 32'h0); wr(4'h5, 32'h0);
      wr(4'h4, 32'hFFFF_FFFF); wr(4'h1, 32'h0); wr(4'h3, 32'h0);
      settle();
      rd(4'h0, 32'h0, "R5 cleanup");
      // R9 boundary indices 0 and 31
      wr(4'h1, 32'h8000_0001); wr(4'h3, 32'h8000_0001);
      irq_in[0] = 1'b1; irq_in[31] = 1'b1;
      settle();
      rd(4'h0, 32'h8000_0001, "R3 bits 0 and 31");
      outs(1'b1, 1'b0, "R7 both crit");
      rd(4'h8, BASE, "R9 idx0 wins");
      wr(4'h6, 32'h1);
      rd(4'h8, BASE + 32'h3E00, "R9 idx31 wins");
      // R7 rerouting
      wr(4'h3, 32'h1);
      settle();
      outs(1'b1, 1'b1, "R7 split");
      rd(4'h8, BASE, "R8 only idx0 critical");
      wr(4'h3, 32'h0);
      settle();
      outs(1'b0, 1'b1, "R7 all noncrit");
      rd(4'h8, BASE, "R8 none critical");
      // R6 disabled
      wr(4'h1, 32'h0);
      settle();
      rd(4'h0, 32'h8000_0001, "R6 status kept");
      rd(4'h2, 32'h0, "R6 masked zero");
      outs(1'b0, 1'b0, "R6 disabled");
      settle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule